// File: doc/BRIEF.md
# Interpolating Quarter-Wave Sine Oscillator

This block generates a signed sine wave from a phase accumulator. Each enabled clock cycle a two's-complement phase register adds a frequency word. The register wraps freely, so overflow and underflow give modulo-one-turn phase without extra logic. The frequency word is already in phase units: one full turn is 2^PHASE_W.

The top two phase bits pick the quadrant. The next bits address a small table that covers only the first quarter of the wave. Each table word holds a base sample and the difference to the next sample. Both come out of one read, and a short multiply of the slope by the fractional phase bits fills in between the stored points. Odd quadrants read the table backwards, by complementing both the index and the fraction. The upper half-turn negates the result. The table is built at elaboration time. The output appears after a fixed three clock-enabled cycles.

Top module: `quarter_sine_osc`

## Requirements
- R1: A synchronous active-high `rst` clears the phase register and every pipeline register; `sample_o` reads 0 on the cycle after reset.
- R2: On each cycle with `ce` high and `phase_clr` low, the phase register becomes (phase + `freq_word`) mod 2^24. A negative word counts down through zero without saturating.
- R3: Phase bits 23:22 form the quadrant q, bits 21:16 the table index, and bits 15:7 the 9-bit fraction. Bits 6:0 only carry resolution into later sums and never reach the output directly.
- R4: Table point k, for k = 0..64, equals round(16383·sin(k·π/128)). Stored word k holds point k as the base and point k+1 minus point k as a 9-bit unsigned slope.
- R5: The magnitude is base + floor(slope·fraction / 512), computed on the index and fraction after mirroring.
- R6: When q bit 0 is 1 (quadrants 1 and 3), the index is replaced by 63 − index and the fraction by 511 − fraction before the table read.
- R7: When q bit 1 is 1 (quadrants 2 and 3), the output is the two's-complement negative of the magnitude. Otherwise the output is the magnitude itself. The output is 15 bits signed.
- R8: Suppose the phase register holds P just before an enabled clock edge. Then after the third enabled edge from that one, counting it as the first, `sample_o` shows the sample for P.
- R9: While `ce` is low, the phase register and all pipeline registers hold, so `sample_o` stays unchanged whatever `freq_word` or `phase_clr` do.
- R10: On a cycle with `ce` high and `phase_clr` high, the phase register loads 0 instead of adding the frequency word. Samples already in the pipeline still emerge in order.
- R11: `sample_o` always lies within −16383..16383.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable; advances the accumulator and the pipeline |
| phase_clr | input | 1 | Loads zero phase on an enabled cycle |
| freq_word | input | 24 | Phase increment per enabled cycle, two's complement |
| sample_o | output | 15 | Signed sine sample, registered |

## Verification
The assertions assume that `freq_word`, `ce` and `phase_clr` change only between clock edges. They also assume that `phase_clr` matters only when `ce` is high. The magnitude bound relies on every table slope fitting in 9 bits. Given that, base plus interpolated step never passes the peak sample.

The stimulus changes inputs only on the falling edge. It stalls with `ce` low while varying the other inputs. It issues `phase_clr` together with `ce`, so every assumption holds. A sweep with a step of 128 visits every quadrant, index and fraction exactly once.

// File: rtl/qso_pkg.sv
package qso_pkg;

  // One point of the quarter-wave: round(full_scale * sin(k * pi / (2 * 2^idx_w)))
  function automatic int quarter_point(input int k, input int idx_w, input int amp_w);
    real ang;
    real full;
    ang  = 3.141592653589793 * real'(k) / (2.0 * real'(1 << idx_w));
    full = real'((1 << amp_w) - 1);
    return $rtoi(full * $sin(ang) + 0.5);
  endfunction

  // Composite word: {base sample, slope to the next point}
  function automatic logic [63:0] table_entry(input int k, input int idx_w,
                                              input int amp_w, input int slope_w);
    int          here;
    int          next;
    logic [63:0] slope_mask;
    here       = quarter_point(k, idx_w, amp_w);
    next       = quarter_point(k + 1, idx_w, amp_w);
    slope_mask = (64'd1 << slope_w) - 64'd1;
    return (64'(here) << slope_w) | (64'(next - here) & slope_mask);
  endfunction

endpackage

// File: rtl/qso_phase_acc.sv
module qso_phase_acc #(
  parameter int PHASE_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce,
  input  logic               clr,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] phase_q
);

  // Free-running wrap gives modulo-one-turn phase for positive and negative steps.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (ce) begin
      phase_q <= clr ? '0 : phase_q + step;
    end
  end

endmodule

// File: rtl/qso_fold.sv
module qso_fold #(
  parameter int IDX_W  = 6,
  parameter int FRAC_W = 9
) (
  input  logic [IDX_W+FRAC_W+1:0] phase_hi,
  output logic [IDX_W-1:0]        addr,
  output logic [FRAC_W-1:0]       frac,
  output logic                    neg
);

  localparam int QUAD_LSB = IDX_W + FRAC_W;

  logic [1:0]        quad;
  logic [IDX_W-1:0]  raw_idx;
  logic [FRAC_W-1:0] raw_frac;

  assign quad     = phase_hi[QUAD_LSB+1:QUAD_LSB];
  assign raw_idx  = phase_hi[QUAD_LSB-1:FRAC_W];
  assign raw_frac = phase_hi[FRAC_W-1:0];

  // Odd quadrants walk the quarter table backwards, fraction included.
  always_comb begin
    if (quad[0]) begin
      addr = ~raw_idx;
      frac = ~raw_frac;
    end else begin
      addr = raw_idx;
      frac = raw_frac;
    end
    neg = quad[1];
  end

endmodule

// File: rtl/qso_rom.sv
module qso_rom #(
  parameter int IDX_W   = 6,
  parameter int AMP_W   = 14,
  parameter int SLOPE_W = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ce,
  input  logic [IDX_W-1:0]           addr,
  output logic [AMP_W+SLOPE_W-1:0]   data_q
);

  localparam int DEPTH   = 2 ** IDX_W;
  localparam int ENTRY_W = AMP_W + SLOPE_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  // Contents computed at elaboration; the entry past the last index only feeds a slope.
  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      mem[k] = ENTRY_W'(qso_pkg::table_entry(k, IDX_W, AMP_W, SLOPE_W));
    end
  end

  // Registered read with a synchronous output reset, suited to block RAM.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (ce) begin
      data_q <= mem[addr];
    end
  end

endmodule

// File: rtl/qso_interp.sv
module qso_interp #(
  parameter int AMP_W   = 14,
  parameter int SLOPE_W = 9,
  parameter int FRAC_W  = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce,
  input  logic [AMP_W+SLOPE_W-1:0] entry,
  input  logic [FRAC_W-1:0]        frac,
  input  logic                     neg_in,
  output logic [AMP_W-1:0]         mag_q,
  output logic                     neg_q
);

  localparam int PROD_W = SLOPE_W + FRAC_W;

  logic [AMP_W-1:0]   base;
  logic [SLOPE_W-1:0] slope;
  logic [PROD_W-1:0]  prod;
  logic [AMP_W-1:0]   sum;

  assign base  = entry[AMP_W+SLOPE_W-1:SLOPE_W];
  assign slope = entry[SLOPE_W-1:0];
  assign prod  = PROD_W'(slope) * PROD_W'(frac);
  // The step is below one slope, so the sum never passes the next table point.
  assign sum   = base + AMP_W'(prod[PROD_W-1:FRAC_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
      neg_q <= 1'b0;
    end else if (ce) begin
      mag_q <= sum;
      neg_q <= neg_in;
    end
  end

endmodule

// File: rtl/quarter_sine_osc.sv
module quarter_sine_osc #(
  parameter int PHASE_W = 24,
  parameter int IDX_W   = 6,
  parameter int FRAC_W  = 9,
  parameter int AMP_W   = 14,
  parameter int SLOPE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ce,
  input  logic                      phase_clr,
  input  logic [PHASE_W-1:0]        freq_word,
  output logic signed [AMP_W:0]     sample_o
);

  localparam int FRAC_LSB = PHASE_W - 2 - IDX_W - FRAC_W;
  localparam int ENTRY_W  = AMP_W + SLOPE_W;

  logic [PHASE_W-1:0] phase_q;
  logic [IDX_W-1:0]   addr_s0;
  logic [FRAC_W-1:0]  frac_s0;
  logic               neg_s0;
  logic [ENTRY_W-1:0] entry_s1;
  logic [FRAC_W-1:0]  frac_s1;
  logic               neg_s1;
  logic [AMP_W-1:0]   mag_s2;
  logic               neg_s2;

  qso_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .clr     (phase_clr),
    .step    (freq_word),
    .phase_q (phase_q)
  );

  qso_fold #(.IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_fold (
    .phase_hi (phase_q[PHASE_W-1:FRAC_LSB]),
    .addr     (addr_s0),
    .frac     (frac_s0),
    .neg      (neg_s0)
  );

  // Stage 1: table read alongside the fraction and sign it belongs to.
  qso_rom #(.IDX_W(IDX_W), .AMP_W(AMP_W), .SLOPE_W(SLOPE_W)) u_rom (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .addr   (addr_s0),
    .data_q (entry_s1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_s1 <= '0;
      neg_s1  <= 1'b0;
    end else if (ce) begin
      frac_s1 <= frac_s0;
      neg_s1  <= neg_s0;
    end
  end

  // Stage 2: interpolating multiply-add.
  qso_interp #(.AMP_W(AMP_W), .SLOPE_W(SLOPE_W), .FRAC_W(FRAC_W)) u_interp (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .entry  (entry_s1),
    .frac   (frac_s1),
    .neg_in (neg_s1),
    .mag_q  (mag_s2),
    .neg_q  (neg_s2)
  );

  // Stage 3: sign applied last, output registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
    end else if (ce) begin
      sample_o <= neg_s2 ? -$signed({1'b0, mag_s2}) : $signed({1'b0, mag_s2});
    end
  end

endmodule

// File: rtl/quarter_sine_osc_chk.sv
module quarter_sine_osc_chk #(
  parameter int PHASE_W = 24,
  parameter int AMP_W   = 14
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ce,
  input logic                  phase_clr,
  input logic [PHASE_W-1:0]    freq_word,
  input logic [PHASE_W-1:0]    phase_q,
  input logic signed [AMP_W:0] sample_o
);

  localparam int LIMIT = (2 ** AMP_W) - 1;

  logic rst_seen = 1'b0;

  always_ff @(posedge clk) rst_seen <= rst;

  always @(posedge clk) begin
    if (rst_seen) begin
      AST_RESET_ZERO: assert (sample_o == '0) else $error("output not cleared by reset"); // R1
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (ce && !phase_clr) |=> (phase_q == $past(phase_q) + $past(freq_word))); // R2

  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ce && phase_clr) |=> (phase_q == '0)); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(sample_o) && $stable(phase_q))); // R9

  AST_MAG_RANGE: assert property (@(posedge clk) disable iff (rst)
    (sample_o <= LIMIT) && (sample_o >= -LIMIT)); // R11

endmodule

bind quarter_sine_osc quarter_sine_osc_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce        (ce),
  .phase_clr (phase_clr),
  .freq_word (freq_word),
  .phase_q   (phase_q),
  .sample_o  (sample_o)
);

// File: tb/sim_quarter_sine_osc.sv
module sim_quarter_sine_osc;

  localparam int PW = 24;
  localparam int AW = 14;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ce = 1'b0;
  logic              phase_clr = 1'b0;
  logic [PW-1:0]     freq_word = '0;
  logic signed [AW:0] sample_o;

  int n_chk  = 0;
  int n_fail = 0;
  int tab [65];
  logic [PW-1:0] p_mod = '0;
  int e1 = 0;
  int e2 = 0;
  int e3 = 0;

  always #10 clk = ~clk;

  quarter_sine_osc u0 (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .phase_clr (phase_clr),
    .freq_word (freq_word),
    .sample_o  (sample_o)
  );

  // R4 R5 R6 R7: expected sample for a phase value
  function automatic int expect_of(input logic [PW-1:0] ph);
    int q;
    int ix;
    int fr;
    int a;
    int b;
    int mag;
    q  = int'(ph[23:22]);
    ix = int'(ph[21:16]);
    fr = int'(ph[15:7]);
    if ((q & 1) != 0) begin
      ix = 63 - ix;
      fr = 511 - fr;
    end
    a   = tab[ix];
    b   = tab[ix + 1] - a;
    mag = a + (b * fr) / 512;
    return ((q & 2) != 0) ? -mag : mag;
  endfunction

  task automatic check(input string tag, input int exp);
    n_chk++;
    if (int'(sample_o) != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, int'(sample_o), exp);
    end
  endtask

  // One clock: inputs at the falling edge, model at the rising edge, sample 5 ns later.
  task automatic tick(input bit ce_v, input bit clr_v, input string tag, input bit do_chk);
    @(negedge clk);
    ce        = ce_v;
    phase_clr = clr_v;
    @(posedge clk);
    if (ce_v && !rst) begin
      e3 = e2;
      e2 = e1;
      e1 = expect_of(p_mod);
      p_mod = clr_v ? '0 : p_mod + freq_word;
    end
    #5;
    if (do_chk) check(tag, e3);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ce  = 1'b0;
    phase_clr = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #5;
    p_mod = '0;
    e1 = 0;
    e2 = 0;
    e3 = 0;
    check("R1 reset output", 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 195000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 65; k++) begin
      tab[k] = $rtoi(16383.0 * $sin(3.141592653589793 * real'(k) / 128.0) + 0.5);
    end
    // R4 sanity on the computed points
    if (tab[64] != 16383 || tab[0] != 0) begin
      n_fail++;
      $display("FAIL R4 table ends: got %0d expected 16383", tab[64]);
    end
    n_chk++;

    do_reset();

    // R8: quarter-turn step; the first phase reaches the output on the third enabled edge
    freq_word = 24'h400000;
    tick(1, 0, "R8 latency edge1", 1);
    tick(1, 0, "R8 latency edge2", 1);
    tick(1, 0, "R8 latency edge3", 1);
    tick(1, 0, "R8 latency edge4", 1);
    n_chk++;
    if (int'(sample_o) != expect_of(24'h400000)) begin
      n_fail++;
      $display("FAIL R8 second sample: got %0d expected %0d", int'(sample_o), expect_of(24'h400000));
    end
    for (int i = 0; i < 8; i++) tick(1, 0, "R6 R7 quarter steps", 1);

    // R3 R5 R6 R7: every quadrant, index and fraction once
    do_reset();
    freq_word = 24'd128;
    for (int i = 0; i < 131075; i++) tick(1, 0, "R5 sweep", 1);

    // R2: negative step with low bits, wrapping downward through zero
    freq_word = 24'hFFF3A1;
    for (int i = 0; i < 2500; i++) tick(1, 0, "R2 wrap down", 1);

    // R3: low phase bits carry into the fraction only through accumulation
    freq_word = 24'h00007F;
    for (int i = 0; i < 600; i++) tick(1, 0, "R3 low bits", 1);
    freq_word = 24'h0A3D71;
    for (int i = 0; i < 600; i++) tick(1, 0, "R2 large step", 1);

    // R9: stall while the other inputs move
    for (int i = 0; i < 20; i++) begin
      freq_word = 24'(i * 24'h13579);
      tick(0, (i % 3) == 0, "R9 stall", 1);
    end
    freq_word = 24'h0A3D71;
    for (int i = 0; i < 10; i++) tick(1, 0, "R9 resume", 1);

    // R10: phase clear mid-run, earlier samples still drain
    tick(1, 1, "R10 clear edge", 1);
    for (int i = 0; i < 12; i++) tick(1, 0, "R10 after clear", 1);

    // R1: reset in the middle of a run
    do_reset();
    freq_word = 24'h123456;
    for (int i = 0; i < 40; i++) tick(1, 0, "R1 post reset run", 1);

    finish_run();
  end

endmodule